// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Writer

This block is the receive half of a scatter-gather DMA channel. Packet data arrives on a 32-bit valid/ready stream with byte-keep and a last flag. The block walks a linked list of in-memory descriptors and writes the incoming bytes into the buffer each one points at. A packet that is longer than one descriptor's buffer is spread over as many descriptors as it needs. When a descriptor is finished, the block writes a status word back into it. On the descriptor that ends a packet, it also writes five sideband words and raises a one-cycle completion pulse. The five sideband words arrive on a separate control stream.

Software, or a register block outside this one, sets three things: the current descriptor pointer, the tail pointer and a run bit. The block talks to memory over a simple port. Each access is one word, writes carry byte strobes, and read data returns one cycle after the request reaches memory. Each descriptor is sixteen 32-bit words wide in memory, laid out as follows:
- next pointer at byte offset 0x00
- buffer address at 0x08
- control word at 0x18, with the buffer length in bytes in bits [22:0]
- status word at 0x1C
- the five sideband words at 0x20, 0x24, 0x28, 0x2C and 0x30

Top module: `s2m_desc_writer`

## Requirements
- R1: After reset, `s_ready_o`, `done_o`, `halted_o` and `mem_en_o` are 0 and `idle_o` is 1.
- R2: The control stream latches one set of sideband words after every fifth accepted word. The latched set is written, in arrival order, to offsets 0x20 to 0x30 of each descriptor that ends a packet. Descriptors that do not end a packet keep their sideband slots unchanged.
- R3: A fetched descriptor whose status bit 31 is already 1 sets `halted_o`. No data is accepted into it, and neither the descriptor nor its buffer is written.
- R4: Bytes land in the buffer in stream order. A descriptor never receives more bytes than the length in its control bits [22:0]. It is closed once the room left in it is less than one 4-byte beat, or when it accepts a beat flagged last. A packet that exactly fills a descriptor ends in that descriptor.
- R5: The descriptor that takes a beat flagged last gets status bit 26 set. `done_o` pulses for exactly one cycle, in the cycle the status word is written.
- R6: Status bit 27 marks the first descriptor of a packet. The flag behind it is 1 after reset and takes the value of bit 26 after each descriptor. This still holds when the channel went idle in the middle of a packet.
- R7: Every written-back status word has bit 31 set and holds the number of bytes written in bits [22:0]. All other bits are 0.
- R8: After a descriptor is written back, the current pointer takes its next pointer. Finishing the descriptor at the tail pointer sets `idle_o`. A tail-pointer write clears `idle_o` and resumes processing from the current pointer.
- R9: `s_ready_o` is 0 whenever `run_i` is 0 or `idle_o` is 1.
- R10: Every memory address is word aligned. Data writes carry the beat's keep as byte strobes, so a partial final beat leaves the other bytes of that word unchanged.
- R11: Loading a new current pointer clears `halted_o`. A later tail write restarts the channel from the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Channel run enable |
| cur_wr_i | input | 1 | Load strobe for the current descriptor pointer |
| cur_addr_i | input | ADDR_W | New current descriptor pointer |
| tail_wr_i | input | 1 | Load strobe for the tail pointer (clears idle) |
| tail_addr_i | input | ADDR_W | New tail descriptor pointer |
| s_data_i | input | 32 | Data stream payload, byte lane 0 in bits [7:0] |
| s_keep_i | input | 4 | Data stream byte keep, low lanes contiguous |
| s_last_i | input | 1 | Data stream end-of-packet flag |
| s_valid_i | input | 1 | Data stream valid |
| s_ready_o | output | 1 | Data stream ready |
| c_data_i | input | 32 | Control stream sideband word |
| c_valid_i | input | 1 | Control stream word valid |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (0 = read) |
| mem_addr_o | output | ADDR_W | Memory byte address, word aligned |
| mem_be_o | output | 4 | Memory write byte strobes |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the request is seen |
| done_o | output | 1 | One-cycle pulse when a packet's last descriptor completes |
| idle_o | output | 1 | Tail descriptor finished; waiting for a tail write |
| halted_o | output | 1 | Stopped on an already-completed descriptor |

## Verification
The bound assertions check four things on every cycle:
- backpressure follows the run, idle and halt conditions;
- the completion pulse lasts one cycle and coincides with an end-of-packet status write;
- every address is word aligned;
- every write carries at least one strobe.

Other behaviour only shows in the bench's scenarios, because it is visible only in memory after a descriptor chain has been walked. This covers how packets split across descriptors, the status encodings, where the sideband words land and how the start flag carries across an idle gap. The bench compares that memory image against values it computes itself. It also drives directed cases for an exact buffer fill, a partial final word, a stall with run low, a halt on a pre-completed descriptor, and recovery by a pointer reload.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTES      = WORD_W / 8;
  localparam int STAT_LEN_W = 23;

  // descriptor word offsets (bytes)
  localparam int OFF_NEXT = 0;
  localparam int OFF_BUF  = 8;
  localparam int OFF_CTRL = 24;
  localparam int OFF_STAT = 28;
  localparam int OFF_APP  = 32;

  typedef enum logic [2:0] {
    E_STOP, E_FETCH, E_CHECK, E_DATA, E_WB, E_ADV
  } eng_state_e;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic sof, input logic eof, input logic [STAT_LEN_W-1:0] cnt);
    logic [WORD_W-1:0] w;
    w = '0;
    w[31] = 1'b1;
    w[27] = sof;
    w[26] = eof;
    w[STAT_LEN_W-1:0] = cnt;
    return w;
  endfunction
endpackage

// File: rtl/s2m_keep_count.sv
module s2m_keep_count #(
  parameter int BYTES = 4,
  parameter int CNT_W = $clog2(BYTES) + 1
) (
  input  logic [BYTES-1:0] keep_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] acc [0:BYTES];

  assign acc[0] = '0;
  for (genvar g = 0; g < BYTES; g++) begin : g_sum
    assign acc[g+1] = acc[g] + CNT_W'(keep_i[g]);
  end
  assign count_o = acc[BYTES];
endmodule

// File: rtl/s2m_app_latch.sv
module s2m_app_latch #(
  parameter int APP_N = 5,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  logic [W-1:0]             data_i,
  output logic [APP_N-1:0][W-1:0]  app_o
);
  localparam int IDX_W = (APP_N > 1) ? $clog2(APP_N) : 1;

  logic [IDX_W-1:0]          idx_q;
  logic [APP_N-1:0][W-1:0]   stage_q;
  logic [APP_N-1:0][W-1:0]   app_q;
  logic                      final_word;

  assign final_word = (idx_q == IDX_W'(APP_N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      stage_q <= '0;
    end else if (valid_i) begin
      idx_q <= final_word ? '0 : idx_q + 1'b1;
      stage_q[idx_q] <= data_i;
    end
  end

  // the whole set becomes visible only after the fifth word
  always_ff @(posedge clk) begin
    if (rst) begin
      app_q <= '0;
    end else if (valid_i && final_word) begin
      for (int k = 0; k < APP_N - 1; k++) app_q[k] <= stage_q[k];
      app_q[APP_N-1] <= data_i;
    end
  end

  assign app_o = app_q;
endmodule

// File: rtl/s2m_engine.sv
module s2m_engine
  import s2m_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int APP_N  = 5,
  parameter int CNT_W  = $clog2(BYTES) + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run_i,
  input  logic                         cur_wr_i,
  input  logic [ADDR_W-1:0]            cur_addr_i,
  input  logic                         tail_wr_i,
  input  logic [ADDR_W-1:0]            tail_addr_i,
  input  logic [WORD_W-1:0]            s_data_i,
  input  logic [BYTES-1:0]             s_keep_i,
  input  logic                         s_last_i,
  input  logic                         s_valid_i,
  input  logic [CNT_W-1:0]             beat_bytes_i,
  output logic                         s_ready_o,
  input  logic [APP_N-1:0][WORD_W-1:0] app_i,
  output logic                         mem_en_o,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [BYTES-1:0]             mem_be_o,
  output logic [WORD_W-1:0]            mem_wdata_o,
  input  logic [WORD_W-1:0]            mem_rdata_i,
  output logic                         done_o,
  output logic                         idle_o,
  output logic                         halted_o
);
  localparam int FC_W = 3;
  localparam int WI_W = $clog2(APP_N + 1);
  localparam logic [STAT_LEN_W-1:0] ONE_BEAT = STAT_LEN_W'(BYTES);
  localparam logic [STAT_LEN_W-1:0] TWO_BEAT = STAT_LEN_W'(2 * BYTES);

  eng_state_e              state_q;
  logic [ADDR_W-1:0]       cur_q, tail_q, nxt_q, wptr_q;
  logic [WORD_W-1:0]       stat_q;
  logic [STAT_LEN_W-1:0]   room_q, cnt_q;
  logic                    eop_q, sof_q, idle_q, halt_q;
  logic [FC_W-1:0]         fc_q;
  logic [WI_W-1:0]         wi_q;

  logic                    men_q, mwe_q, done_q;
  logic [ADDR_W-1:0]       maddr_q;
  logic [BYTES-1:0]        mbe_q;
  logic [WORD_W-1:0]       mwdata_q;

  logic                    take;

  function automatic logic [ADDR_W-1:0] fetch_off(input logic [FC_W-1:0] fc);
    case (fc)
      3'd0:    return ADDR_W'(OFF_STAT);
      3'd1:    return ADDR_W'(OFF_CTRL);
      3'd2:    return ADDR_W'(OFF_BUF);
      default: return ADDR_W'(OFF_NEXT);
    endcase
  endfunction

  assign s_ready_o = (state_q == E_DATA) && run_i;
  assign take      = s_valid_i && s_ready_o;

  always_ff @(posedge clk) begin
    men_q  <= 1'b0;
    mwe_q  <= 1'b0;
    mbe_q  <= '0;
    done_q <= 1'b0;
    if (rst) begin
      state_q  <= E_STOP;
      cur_q    <= '0;
      tail_q   <= '0;
      nxt_q    <= '0;
      wptr_q   <= '0;
      stat_q   <= '0;
      room_q   <= '0;
      cnt_q    <= '0;
      eop_q    <= 1'b0;
      sof_q    <= 1'b1;
      idle_q   <= 1'b1;
      halt_q   <= 1'b0;
      fc_q     <= '0;
      wi_q     <= '0;
      maddr_q  <= '0;
      mwdata_q <= '0;
    end else begin
      case (state_q)
        E_STOP: begin
          fc_q <= '0;
          if (run_i && !idle_q && !halt_q) state_q <= E_FETCH;
        end

        E_FETCH: begin
          // four reads issued back to back; data returns two cycles later
          if (fc_q < FC_W'(4)) begin
            men_q   <= 1'b1;
            maddr_q <= cur_q + fetch_off(fc_q);
          end
          fc_q <= fc_q + 1'b1;
          case (fc_q)
            3'd2: stat_q <= mem_rdata_i;
            3'd3: room_q <= mem_rdata_i[STAT_LEN_W-1:0];
            3'd4: wptr_q <= mem_rdata_i[ADDR_W-1:0];
            3'd5: begin
              nxt_q   <= mem_rdata_i[ADDR_W-1:0];
              state_q <= E_CHECK;
            end
            default: ;
          endcase
        end

        E_CHECK: begin
          cnt_q <= '0;
          eop_q <= 1'b0;
          wi_q  <= '0;
          if (stat_q[31]) begin
            halt_q  <= 1'b1;
            state_q <= E_STOP;
          end else if (room_q < ONE_BEAT) begin
            state_q <= E_WB;
          end else begin
            state_q <= E_DATA;
          end
        end

        E_DATA: begin
          if (take) begin
            men_q    <= 1'b1;
            mwe_q    <= 1'b1;
            maddr_q  <= wptr_q;
            mbe_q    <= s_keep_i;
            mwdata_q <= s_data_i;
            wptr_q   <= wptr_q + ADDR_W'(BYTES);
            cnt_q    <= cnt_q + STAT_LEN_W'(beat_bytes_i);
            room_q   <= room_q - ONE_BEAT;
            if (s_last_i) begin
              eop_q   <= 1'b1;
              state_q <= E_WB;
            end else if (room_q < TWO_BEAT) begin
              state_q <= E_WB;
            end
          end
        end

        E_WB: begin
          men_q <= 1'b1;
          mwe_q <= 1'b1;
          mbe_q <= '1;
          if (eop_q && (int'(wi_q) < APP_N)) begin
            maddr_q  <= cur_q + ADDR_W'(OFF_APP) + ADDR_W'(int'(wi_q) * BYTES);
            mwdata_q <= app_i[wi_q];
            wi_q     <= wi_q + 1'b1;
          end else begin
            maddr_q  <= cur_q + ADDR_W'(OFF_STAT);
            mwdata_q <= pack_status(sof_q, eop_q, cnt_q);
            done_q   <= eop_q;
            sof_q    <= eop_q;
            state_q  <= E_ADV;
          end
        end

        E_ADV: begin
          cur_q   <= nxt_q;
          if (cur_q == tail_q) idle_q <= 1'b1;
          state_q <= E_STOP;
        end

        default: state_q <= E_STOP;
      endcase

      // pointer loads take priority over the sequencer's own updates
      if (cur_wr_i) begin
        cur_q  <= cur_addr_i;
        halt_q <= 1'b0;
      end
      if (tail_wr_i) begin
        tail_q <= tail_addr_i;
        idle_q <= 1'b0;
      end
    end
  end

  assign mem_en_o    = men_q;
  assign mem_we_o    = mwe_q;
  assign mem_addr_o  = maddr_q;
  assign mem_be_o    = mbe_q;
  assign mem_wdata_o = mwdata_q;
  assign done_o      = done_q;
  assign idle_o      = idle_q;
  assign halted_o    = halt_q;
endmodule

// File: rtl/s2m_desc_writer.sv
module s2m_desc_writer
  import s2m_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int APP_N  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic                cur_wr_i,
  input  logic [ADDR_W-1:0]   cur_addr_i,
  input  logic                tail_wr_i,
  input  logic [ADDR_W-1:0]   tail_addr_i,
  input  logic [WORD_W-1:0]   s_data_i,
  input  logic [BYTES-1:0]    s_keep_i,
  input  logic                s_last_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [WORD_W-1:0]   c_data_i,
  input  logic                c_valid_i,
  output logic                mem_en_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [BYTES-1:0]    mem_be_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic                done_o,
  output logic                idle_o,
  output logic                halted_o
);
  localparam int CNT_W = $clog2(BYTES) + 1;

  logic [CNT_W-1:0]             beat_bytes;
  logic [APP_N-1:0][WORD_W-1:0] app_words;

  s2m_keep_count #(.BYTES(BYTES), .CNT_W(CNT_W)) u_keep (
    .keep_i  (s_keep_i),
    .count_o (beat_bytes)
  );

  s2m_app_latch #(.APP_N(APP_N), .W(WORD_W)) u_app (
    .clk     (clk),
    .rst     (rst),
    .valid_i (c_valid_i),
    .data_i  (c_data_i),
    .app_o   (app_words)
  );

  s2m_engine #(.ADDR_W(ADDR_W), .APP_N(APP_N), .CNT_W(CNT_W)) u_eng (
    .clk          (clk),
    .rst          (rst),
    .run_i        (run_i),
    .cur_wr_i     (cur_wr_i),
    .cur_addr_i   (cur_addr_i),
    .tail_wr_i    (tail_wr_i),
    .tail_addr_i  (tail_addr_i),
    .s_data_i     (s_data_i),
    .s_keep_i     (s_keep_i),
    .s_last_i     (s_last_i),
    .s_valid_i    (s_valid_i),
    .beat_bytes_i (beat_bytes),
    .s_ready_o    (s_ready_o),
    .app_i        (app_words),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_be_o     (mem_be_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (done_o),
    .idle_o       (idle_o),
    .halted_o     (halted_o)
  );
endmodule

// File: rtl/s2m_desc_writer_chk.sv
module s2m_desc_writer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run_i,
  input logic              s_ready_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic [31:0]       mem_wdata_o,
  input logic              done_o,
  input logic              idle_o,
  input logic              halted_o
);
  assert_ready_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_i || idle_o) |-> !s_ready_o);

  assert_halt_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !s_ready_o);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_with_status_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (mem_en_o && mem_we_o && mem_wdata_o[31] && mem_wdata_o[26]));

  assert_word_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    mem_en_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_write_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && mem_we_o) |-> (mem_be_o != 4'b0000));
endmodule

bind s2m_desc_writer s2m_desc_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_i       (run_i),
  .s_ready_o   (s_ready_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o),
  .done_o      (done_o),
  .idle_o      (idle_o),
  .halted_o    (halted_o)
);

// File: tb/s2m_desc_writer_test.sv
`timescale 1ns/1ps
module s2m_desc_writer_test;
  localparam int AW = 32;
  localparam logic [31:0] DBASE = 32'h100;
  localparam logic [31:0] BBASE = 32'h1000;
  localparam logic [31:0] FILL  = 32'hA5A5_A5A5;
  localparam int NPKT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic cur_wr = 1'b0, tail_wr = 1'b0;
  logic [AW-1:0] cur_addr = '0, tail_addr = '0;
  logic [31:0] s_data = '0;
  logic [3:0]  s_keep = '0;
  logic s_last = 1'b0, s_valid = 1'b0, s_ready;
  logic [31:0] c_data = '0;
  logic c_valid = 1'b0;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic done, idle, halted;

  logic tb_we = 1'b0;
  logic [31:0] tb_waddr = '0, tb_wdata = '0;
  logic [31:0] mem [0:2047];

  int tests = 0, fails = 0, done_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  s2m_desc_writer uut (
    .clk(clk), .rst(rst), .run_i(run),
    .cur_wr_i(cur_wr), .cur_addr_i(cur_addr),
    .tail_wr_i(tail_wr), .tail_addr_i(tail_addr),
    .s_data_i(s_data), .s_keep_i(s_keep), .s_last_i(s_last),
    .s_valid_i(s_valid), .s_ready_o(s_ready),
    .c_data_i(c_data), .c_valid_i(c_valid),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .idle_o(idle), .halted_o(halted)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we)
        for (int j = 0; j < 4; j++)
          if (mem_be[j]) mem[mem_addr[12:2]][8*j +: 8] <= mem_wdata[8*j +: 8];
      mem_rdata <= mem[mem_addr[12:2]];
    end
    if (tb_we) mem[tb_waddr[12:2]] <= tb_wdata;
  end

  always @(negedge clk) if (!rst && done) done_cnt++;

  // ---------------- reference functions ----------------
  function automatic logic [7:0] pkt_byte(int p, int j);
    return 8'((p * 37 + j * 11 + 5) & 255);
  endfunction
  function automatic logic [31:0] app_val(int p, int k);
    return 32'hC0DE_0000 ^ (32'(p) << 8) ^ 32'(k);
  endfunction
  function automatic logic [31:0] exp_stat(bit sof, bit eof, int cnt);
    return {1'b1, 3'b000, sof, eof, 3'b000, 23'(cnt)};
  endfunction
  function automatic logic [31:0] daddr(int i);
    return DBASE + 32'(i * 64);
  endfunction
  function automatic logic [31:0] baddr(int i);
    return BBASE + 32'(i * 64);
  endfunction
  function automatic logic [31:0] rd(logic [31:0] a);
    return mem[a[12:2]];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- stimulus tasks ----------------
  task automatic tb_wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic setup_desc(int i, int len, int nxt, logic [31:0] st);
    tb_wr(daddr(i) + 0,  daddr(nxt));
    tb_wr(daddr(i) + 8,  baddr(i));
    tb_wr(daddr(i) + 24, 32'(len));
    tb_wr(daddr(i) + 28, st);
    for (int k = 0; k < 5; k++) tb_wr(daddr(i) + 32 + 32'(4 * k), 32'h0);
    for (int w = 0; w < 8; w++) tb_wr(baddr(i) + 32'(4 * w), FILL);
  endtask

  task automatic send_apps(int p);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      c_valid = 1'b1; c_data = app_val(p, k);
    end
    @(negedge clk);
    c_valid = 1'b0;
  endtask

  task automatic load_cur(int i);
    @(negedge clk);
    cur_wr = 1'b1; cur_addr = daddr(i);
    @(negedge clk);
    cur_wr = 1'b0;
  endtask

  task automatic load_tail(int i);
    @(negedge clk);
    tail_wr = 1'b1; tail_addr = daddr(i);
    @(negedge clk);
    tail_wr = 1'b0;
  endtask

  // bytes start..start+n-1 of packet p; last on the final beat if eop
  task automatic send_bytes(int p, int start, int n, bit eop, bit gaps);
    int nb;
    nb = (n + 3) / 4;
    for (int b = 0; b < nb; b++) begin
      int k;
      k = (n - 4 * b > 4) ? 4 : n - 4 * b;
      @(negedge clk);
      s_valid = 1'b1;
      s_keep  = 4'((1 << k) - 1);
      s_last  = eop && (b == nb - 1);
      for (int j = 0; j < 4; j++)
        s_data[8*j +: 8] = (j < k) ? pkt_byte(p, start + 4 * b + j) : 8'hEE;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
      if (gaps) repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    @(negedge clk);
    while (!idle && t < 2000) begin @(negedge clk); t++; end
  endtask

  // buffer of descriptor i holds bytes base..base+used-1 of packet p
  task automatic check_buf(string req, int i, int len, int p, int base, int used);
    for (int w = 0; w < len / 4; w++) begin
      logic [31:0] e;
      for (int j = 0; j < 4; j++)
        e[8*j +: 8] = (4 * w + j < used) ? pkt_byte(p, base + 4 * w + j) : 8'hA5;
      check(req, rd(baddr(i) + 32'(4 * w)), e);
    end
  endtask

  task automatic check_apps(string req, int i, bit present, int p);
    for (int k = 0; k < 5; k++)
      check(req, rd(daddr(i) + 32 + 32'(4 * k)), present ? app_val(p, k) : 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lens [0:7];
    int nd, cap, plen, rem, e, base, d0;
    void'($urandom(32'h5eed_0042));
    run = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R9 ready low while idle
    check("R1 ready", 32'(s_ready), 0);
    check("R1 idle", 32'(idle), 1);
    check("R1 halted", 32'(halted), 0);
    check("R1 done", 32'(done), 0);
    check("R1 mem_en", 32'(mem_en), 0);

    send_apps(200);
    setup_desc(0, 8, 1, 0);
    setup_desc(1, 16, 2, 0);
    setup_desc(2, 16, 3, 0);
    setup_desc(3, 8, 0, 32'h8000_0000);

    // mid-packet idle: desc0 filled by room, no last
    load_cur(0); load_tail(0);
    send_bytes(200, 0, 8, 0, 0);
    wait_idle();
    check("R7 R6 desc0 status", rd(daddr(0) + 28), exp_stat(1, 0, 8));
    check_apps("R2 no apps on non-final", 0, 0, 200);
    check("R8 idle after tail", 32'(idle), 1);
    check("R9 ready low when idle", 32'(s_ready), 0);
    check_buf("R4 desc0 data", 0, 8, 200, 0, 8);

    // resume: sof must stay clear across the idle gap; partial final word
    load_tail(1);
    send_bytes(200, 8, 2, 1, 0);
    wait_idle();
    check("R6 R5 desc1 status", rd(daddr(1) + 28), exp_stat(0, 1, 2));
    check_apps("R2 apps on final", 1, 1, 200);
    check("R5 done count", 32'(done_cnt), 1);
    check("R10 partial word", rd(baddr(1)),
          {8'hA5, 8'hA5, pkt_byte(200, 9), pkt_byte(200, 8)});

    // run low blocks ready
    run = 1'b0;
    load_tail(2);
    @(negedge clk);
    s_valid = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 ready low with run clear", 32'(s_ready), 0);
    s_valid = 1'b0;
    run = 1'b1;
    send_bytes(201, 0, 16, 1, 0);
    wait_idle();
    check("R4 exact fill status", rd(daddr(2) + 28), exp_stat(1, 1, 16));
    check_buf("R4 exact fill data", 2, 16, 201, 0, 16);
    check("R5 done count 2", 32'(done_cnt), 2);

    // pre-completed descriptor halts
    load_tail(3);
    repeat (20) @(negedge clk);
    check("R3 halted", 32'(halted), 1);
    check("R3 ready low", 32'(s_ready), 0);
    check("R3 status untouched", rd(daddr(3) + 28), 32'h8000_0000);
    check("R3 buffer untouched", rd(baddr(3)), FILL);

    // recover by reloading the pointer
    tb_wr(daddr(3) + 28, 32'h0);
    load_cur(3);
    check("R11 halt cleared", 32'(halted), 0);
    load_tail(3);
    send_bytes(202, 0, 3, 1, 0);
    wait_idle();
    check("R11 R8 restart status", rd(daddr(3) + 28), exp_stat(1, 1, 3));
    check("R5 done count 3", 32'(done_cnt), 3);

    // constrained random packets over fresh chains
    for (int p = 0; p < NPKT; p++) begin
      nd = 2 + int'($urandom % 4);
      cap = 0;
      for (int i = 0; i < nd; i++) begin
        lens[i] = 4 * (1 + int'($urandom % 8));
        cap += lens[i];
      end
      plen = 1 + int'($urandom % 32'(cap));
      rem = plen; e = 0;
      for (int i = 0; i < nd; i++) begin
        if (rem > 0) begin
          rem -= (rem > lens[i]) ? lens[i] : rem;
          e = i;
        end
      end
      send_apps(p);
      for (int i = 0; i < nd; i++) setup_desc(i, lens[i], (i + 1) % nd, 0);
      d0 = done_cnt;
      load_cur(0); load_tail(e);
      send_bytes(p, 0, plen, 1, 1);
      wait_idle();
      base = 0;
      for (int i = 0; i < nd; i++) begin
        int used;
        used = (plen - base > lens[i]) ? lens[i] : plen - base;
        if (used < 0) used = 0;
        if (i <= e) begin
          check("R7 R6 R5 random status", rd(daddr(i) + 28),
                exp_stat(i == 0, i == e, used));
          check_buf("R4 random data", i, lens[i], p, base, used);
          check_apps("R2 random apps", i, i == e, p);
        end else begin
          check("R8 beyond tail untouched", rd(daddr(i) + 28), 32'h0);
        end
        base += used;
      end
      check("R5 random done count", 32'(done_cnt - d0), 1);
      check("R8 random idle", 32'(idle), 1);
    end
    finish_run();
  end
endmodule